// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C slave that answers one fixed 7-bit device address and gives an external master access to an internal register space. A write transaction carries an 8-bit subaddress and then one or two data bytes. A read transaction writes the subaddress, issues a repeated START, sends the device address with the read flag set, and then collects one or two bytes. Registers are either 8 or 16 bits wide. A 16-bit register moves as two bytes, with the high byte first.

Register contents live outside the block. They are reached through a byte-wide request/acknowledge bus, and each bus transfer carries one byte. The register file reports the width of the register at the current subaddress, and the slave uses that to decide how many data bytes to accept or supply. While a bus request is pending, the slave holds SCL low, so the register file can take as many cycles as it needs. The SCL and SDA lines are sampled by the local clock after a synchroniser. Both outputs are open-drain enables: a 1 pulls the line low.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset `sda_oe`, `scl_oe` and `rb_req` are all 0, so both bus lines are released and no register access is pending.
- R2: An address byte is sent MSB first. Its upper seven bits are compared with `DEV_ADDR`, and its bit 0 is the direction flag (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch SDA stays released, and every following byte goes unanswered and raises no request until the next START.
- R3: In a write transaction, the first byte after the address is latched as the subaddress and acknowledged. From then on it appears on `rb_addr`.
- R4: Each accepted write data byte produces exactly one request with `rb_we`=1 and the byte on `rb_wdata`. For a register that reports `rb_wide`=1, the first byte is sent with `rb_hi`=1 and the second with `rb_hi`=0. A narrow register takes one byte, sent with `rb_hi`=0. The slave acknowledges a byte only after `rb_ack`.
- R5: From the SCL fall that ends a data byte until `rb_ack` arrives, the slave holds SCL low. The same holds from the SCL fall that ends the read-address acknowledge until the fetched byte is ready.
- R6: A write data byte beyond the register width (a third byte for a wide register, a second for a narrow one) is not acknowledged and raises no request.
- R7: After a repeated START and a matching address with bit 0 = 1, the slave fetches the register at the latched subaddress through a request with `rb_we`=0 and shifts the byte out MSB first. For a wide register, the high byte (`rb_hi`=1) is followed by the low byte (`rb_hi`=0), provided the master acknowledged the high byte.
- R8: When the master answers a read byte with NAK (SDA high in the ninth clock), the slave raises no further request and leaves SDA released.
- R9: A STOP (SDA rising while SCL is high) releases both lines and ends the transfer. A START (SDA falling while SCL is high) aborts any partial byte, discards it without a register write, and restarts address reception. The latched subaddress is kept.
- R10: While `rb_req` is high and `rb_ack` is low, `rb_req`, `rb_we`, `rb_addr`, `rb_hi` and `rb_wdata` hold their values into the next cycle.
- R11: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK or data 0) |
| rb_req | output | 1 | Register-bus request, held until `rb_ack` |
| rb_we | output | 1 | 1 = write request, 0 = read request |
| rb_addr | output | 8 | Latched subaddress |
| rb_hi | output | 1 | 1 = high byte of a wide register |
| rb_wdata | output | 8 | Byte to be written |
| rb_wide | input | 1 | Register at `rb_addr` is 16 bits wide |
| rb_rdata | input | 8 | Byte returned on a read request |
| rb_ack | input | 1 | One-cycle completion of a request |

## Verification
START detection and the shifting of a received data bit can land in the same cycle window: a START can arrive while a write byte is half shifted in, and the slave must abort instead of committing the byte. The bench provokes this by sending four data bits after the subaddress and then forcing a repeated START in the middle of the byte. The result is judged at the ports: no write request is counted, and the following read returns the register's earlier value from the kept subaddress. A second collision happens between the arrival of `rb_ack` and the release of the stretched SCL. This is checked by confirming that SDA already carries the acknowledge before SCL rises, and that SDA never moves while SCL is high.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = 4;
  localparam int IDX_W = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDAT,
    ST_ACK,
    ST_WSTALL,
    ST_WACKH,
    ST_RFETCH,
    ST_RHOLD,
    ST_TX,
    ST_RACK
  } eng_state_t;

  // address byte matches when its upper seven bits equal the device address
  function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
    return b[BYTE_W-1:1] == dev;
  endfunction

  // number of data bytes a register of the given width carries
  function automatic logic [IDX_W-1:0] byte_count(input logic wide);
    return wide ? IDX_W'(2) : IDX_W'(1);
  endfunction

  // the first byte of a wide register is its high half
  function automatic logic hi_lane(input logic wide, input logic [IDX_W-1:0] idx);
    return wide && (idx == '0);
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[s] <= '1;
        end else if (s == 0) begin
          chain[s] <= d_i;
        end else begin
          chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = !scl_q && scl_s;
  assign scl_fall  = scl_q && !scl_s;
  assign start_det = scl_q && scl_s && sda_q && !sda_s;
  assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic              rb_wide,
  input  logic              rb_ack,
  input  logic [BYTE_W-1:0] rb_rdata,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              rb_req,
  output logic              rb_we,
  output logic              rb_hi,
  output logic [BYTE_W-1:0] rb_addr,
  output logic [BYTE_W-1:0] rb_wdata,
  output eng_state_t        state_o
);

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W);

  eng_state_t           state, nxt;
  logic [BYTE_W-1:0]    shreg;
  logic [BYTE_W-1:0]    sub;
  logic [BIT_CNT_W-1:0] cnt;
  logic [IDX_W-1:0]     idx;
  logic                 mack;
  logic                 more_bytes;
  logic                 byte_done;

  assign more_bytes = idx < byte_count(rb_wide);
  assign byte_done  = scl_fall && (cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      nxt   <= ST_IDLE;
      shreg <= '0;
      sub   <= '0;
      cnt   <= '0;
      idx   <= '0;
      mack  <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR;
      cnt   <= '0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WDAT: begin
          if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit(shreg, DEV_ADDR)) begin
                state <= ST_ACK;
                nxt   <= shreg[0] ? ST_RFETCH : ST_SUB;
                idx   <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_SUB) begin
              sub   <= shreg;
              idx   <= '0;
              state <= ST_ACK;
              nxt   <= ST_WDAT;
            end else begin
              state <= more_bytes ? ST_WSTALL : ST_IDLE;
            end
          end
        end
        ST_WSTALL: begin
          if (rb_ack) begin
            idx   <= idx + 1'b1;
            nxt   <= ST_WDAT;
            state <= ST_WACKH;
          end
        end
        ST_WACKH: state <= ST_ACK;
        ST_ACK: begin
          if (scl_fall) begin
            state <= nxt;
            cnt   <= '0;
          end
        end
        ST_RFETCH: begin
          if (rb_ack) begin
            shreg <= rb_rdata;
            idx   <= idx + 1'b1;
            cnt   <= '0;
            state <= ST_RHOLD;
          end
        end
        ST_RHOLD: state <= ST_TX;
        ST_TX: begin
          if (scl_fall) begin
            shreg <= {shreg[BYTE_W-2:0], 1'b1};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT - 1'b1) state <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= !sda_s;
          end else if (scl_fall) begin
            state <= (mack && more_bytes) ? ST_RFETCH : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe   = (state == ST_ACK) || (state == ST_WACKH) ||
                    (((state == ST_RHOLD) || (state == ST_TX)) && !shreg[BYTE_W-1]);
  assign scl_oe   = (state == ST_WSTALL) || (state == ST_WACKH) ||
                    (state == ST_RFETCH) || (state == ST_RHOLD);
  assign rb_req   = (state == ST_WSTALL) || (state == ST_RFETCH);
  assign rb_we    = (state == ST_WSTALL);
  assign rb_hi    = hi_lane(rb_wide, idx);
  assign rb_addr  = sub;
  assign rb_wdata = shreg;
  assign state_o  = state;

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1000111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       rb_req,
  output logic       rb_we,
  output logic [7:0] rb_addr,
  output logic       rb_hi,
  output logic [7:0] rb_wdata,
  input  logic       rb_wide,
  input  logic [7:0] rb_rdata,
  input  logic       rb_ack
);

  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  eng_state_t state;

  i2cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2cs_busmon u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .rb_wide   (rb_wide),
    .rb_ack    (rb_ack),
    .rb_rdata  (rb_rdata),
    .sda_oe    (sda_oe),
    .scl_oe    (scl_oe),
    .rb_req    (rb_req),
    .rb_we     (rb_we),
    .rb_hi     (rb_hi),
    .rb_addr   (rb_addr),
    .rb_wdata  (rb_wdata),
    .state_o   (state)
  );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       rb_req,
  input logic       rb_we,
  input logic       rb_hi,
  input logic [7:0] rb_addr,
  input logic [7:0] rb_wdata,
  input logic       rb_ack
);

  // R5
  stretch_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |-> scl_oe);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_req && !rb_ack) |=> (rb_req && $stable(rb_we) && $stable(rb_addr) &&
                             $stable(rb_hi) && $stable(rb_wdata)));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && !scl_oe && !rb_req));

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && !rb_req));

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

endmodule

bind i2c_reg_slave i2cs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .rb_req    (rb_req),
  .rb_we     (rb_we),
  .rb_hi     (rb_hi),
  .rb_addr   (rb_addr),
  .rb_wdata  (rb_wdata),
  .rb_ack    (rb_ack)
);

// File: tb/i2c_reg_slave_test.sv
module i2c_reg_slave_test;

  localparam int T   = 20;
  localparam int LAT = 12;
  localparam logic [7:0] AW  = 8'h8E;
  localparam logic [7:0] AR  = 8'h8F;
  localparam logic [7:0] AXW = 8'h8A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, rb_req, rb_we, rb_hi, rb_ack, rb_wide;
  logic [7:0] rb_addr, rb_wdata, rb_rdata;
  wire scl_bus = ~(m_scl_low | scl_oe);
  wire sda_bus = ~(m_sda_low | sda_oe);

  assign rb_wide = (rb_addr == 8'h7C) || (rb_addr == 8'h20);

  i2c_reg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rb_req(rb_req), .rb_we(rb_we),
    .rb_addr(rb_addr), .rb_hi(rb_hi), .rb_wdata(rb_wdata),
    .rb_wide(rb_wide), .rb_rdata(rb_rdata), .rb_ack(rb_ack)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, stable_err = 0, r11_bad = 0, stretch_cyc = 0;
  logic [15:0] regs [0:255];
  logic [8:0]  wr_log [0:7];
  logic [8:0]  rd_log [0:7];
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // register-file responder
  initial begin
    for (int i = 0; i < 256; i++) regs[i] = 16'h0;
    rb_ack = 1'b0;
    rb_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (rb_req) begin
        logic [7:0] a, d;
        logic w, h;
        a = rb_addr; w = rb_we; h = rb_hi; d = rb_wdata;
        for (int k = 0; k < LAT; k++) begin
          @(negedge clk);
          if (rb_addr !== a || rb_we !== w || rb_hi !== h || rb_req !== 1'b1) stable_err++;
        end
        rb_rdata = h ? regs[a][15:8] : regs[a][7:0];
        rb_ack = 1'b1;
        if (w) begin
          if (h) regs[a][15:8] = d; else regs[a][7:0] = d;
          wr_log[wr_cnt % 8] = {h, d};
          wr_cnt++;
        end else begin
          rd_log[rd_cnt % 8] = {h, rb_rdata};
          rd_cnt++;
        end
        @(negedge clk);
        rb_ack = 1'b0;
      end
    end
  end

  // R11 monitor and stretch counter
  logic prev_sda_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== prev_sda_oe) && scl_bus) r11_bad++;
    prev_sda_oe <= sda_oe;
    if (scl_oe) stretch_cyc++;
  end

  task automatic half(); repeat (T) @(negedge clk); endtask

  task automatic send_bit(input logic b);
    half(); m_sda_low = !b; half();
    m_scl_low = 1'b0; wait (scl_bus === 1'b1); @(negedge clk);
    half(); half(); m_scl_low = 1'b1;
  endtask

  task automatic recv_bit(output logic b);
    half(); m_sda_low = 1'b0; half();
    m_scl_low = 1'b0; wait (scl_bus === 1'b1); @(negedge clk);
    half(); b = sda_bus; half(); m_scl_low = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin recv_bit(b); v[i] = b; end
    send_bit(!ack);
  endtask

  task automatic do_start();
    m_sda_low = 1'b1; half(); m_scl_low = 1'b1;
  endtask

  task automatic do_rstart();
    half(); m_sda_low = 1'b0; half();
    m_scl_low = 1'b0; wait (scl_bus === 1'b1); @(negedge clk);
    half(); m_sda_low = 1'b1; half(); m_scl_low = 1'b1;
  endtask

  task automatic do_stop();
    half(); m_sda_low = 1'b1; half();
    m_scl_low = 1'b0; wait (scl_bus === 1'b1); @(negedge clk);
    half(); m_sda_low = 1'b0; half(); half();
  endtask

  task automatic t_reset();
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 rb_req", rb_req, 0);
  endtask

  task automatic t_write16();
    logic a;
    int w0;
    w0 = wr_cnt;
    do_start();
    send_byte(AW, a);    chk("R2 address ack", a, 1);
    send_byte(8'h7C, a); chk("R3 subaddress ack", a, 1);
    chk("R3 rb_addr", rb_addr, 8'h7C);
    stretch_cyc = 0;
    send_byte(8'hA5, a); chk("R4 high byte ack", a, 1);
    chk("R5 stretch seen", stretch_cyc >= LAT, 1);
    send_byte(8'h5A, a); chk("R4 low byte ack", a, 1);
    do_stop();
    chk("R4 write count", wr_cnt - w0, 2);
    chk("R4 first is high lane", wr_log[w0 % 8], {1'b1, 8'hA5});
    chk("R4 second is low lane", wr_log[(w0 + 1) % 8], {1'b0, 8'h5A});
    chk("R4 register value", regs[8'h7C], 16'hA55A);
  endtask

  task automatic t_write8_surplus();
    logic a;
    int w0;
    w0 = wr_cnt;
    do_start();
    send_byte(AW, a);    chk("R2 address ack", a, 1);
    send_byte(8'h10, a); chk("R3 subaddress ack", a, 1);
    send_byte(8'h3C, a); chk("R4 narrow byte ack", a, 1);
    send_byte(8'h77, a); chk("R6 surplus nak", a, 0);
    do_stop();
    chk("R6 write count", wr_cnt - w0, 1);
    chk("R4 narrow lane", wr_log[w0 % 8], {1'b0, 8'h3C});
    chk("R6 register value", regs[8'h10], 16'h003C);
  endtask

  task automatic t_read(input logic [7:0] sub, input logic wide, input logic ack_hi,
                        input logic [7:0] e0, input logic [7:0] e1);
    logic a;
    logic [7:0] v;
    int r0;
    r0 = rd_cnt;
    do_start();
    send_byte(AW, a);  chk("R2 address ack", a, 1);
    send_byte(sub, a); chk("R3 subaddress ack", a, 1);
    do_rstart();
    send_byte(AR, a);  chk("R7 read address ack", a, 1);
    recv_byte(wide && ack_hi, v); chk("R7 first read byte", v, e0);
    if (wide && ack_hi) begin
      recv_byte(1'b0, v); chk("R7 second read byte", v, e1);
    end
    half();
    chk("R8 sda released after nak", sda_oe, 0);
    do_stop();
    chk("R9 lines released after stop", {scl_oe, sda_oe}, 2'b00);
    chk("R8 read request count", rd_cnt - r0, (wide && ack_hi) ? 2 : 1);
    chk("R7 first lane", rd_log[r0 % 8][8], wide);
  endtask

  task automatic t_mismatch();
    logic a;
    int w0;
    w0 = wr_cnt;
    do_start();
    send_byte(AXW, a);   chk("R2 mismatch no ack", a, 0);
    send_byte(8'h7C, a); chk("R2 ignored byte", a, 0);
    send_byte(8'h11, a); chk("R2 ignored data", a, 0);
    do_stop();
    chk("R2 no request", wr_cnt - w0, 0);
    chk("R2 register untouched", regs[8'h7C], 16'hA55A);
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] v;
    int w0;
    w0 = wr_cnt;
    do_start();
    send_byte(AW, a);    chk("R2 address ack", a, 1);
    send_byte(8'h10, a); chk("R3 subaddress ack", a, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    do_rstart();
    send_byte(AR, a);    chk("R9 address after abort", a, 1);
    recv_byte(1'b0, v);  chk("R9 subaddress kept", v, 8'h3C);
    do_stop();
    chk("R9 partial byte discarded", wr_cnt - w0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write16();
    t_write8_surplus();
    t_read(8'h7C, 1'b1, 1'b1, 8'hA5, 8'h5A);
    t_read(8'h10, 1'b0, 1'b0, 8'h3C, 8'h00);
    t_read(8'h7C, 1'b1, 1'b0, 8'hA5, 8'h00);
    t_mismatch();
    t_abort();
    chk("R10 request stable", stable_err, 0);
    chk("R11 sda stable while scl high", r11_bad, 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule